// File: doc/BRIEF.md
# Conversion-done interrupt controller

This block collects end-of-conversion events from four converter channels and reports them on two interfaces that run side by side. Toward the programmable logic it gives one-clock done pulses, one per channel. Toward the processor it keeps a sticky 4-bit status nibble and a single interrupt line. A per-channel enable mask filters the status nibble. A processor read strobe clears the status and the interrupt.

When channels are grouped into wider converters, only the first channel of each group reports. In a 9-bit pair this is channel 1 or channel 3. In the 10-bit quad it is channel 1. Events from the other channels in a group are dropped on both interfaces. Events from channels that are set up as DACs are also dropped. The processor-side path does not alter the pulses on the logic side.

Top module: `cdi_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `done_pulse`, `status` and `irq` are all 0.
- R2: A qualified event on channel k (`conv_end[k]` sampled high at a rising clock edge) drives `done_pulse[k]` high for the one cycle that follows that edge. It is low again one cycle later if there is no new event.
- R3: A qualified event on channel k sets `status[k]` at that same edge only if `irq_mask[k]` is 1. A masked channel never sets its status bit.
- R4: Set status bits stay set until a read. They never fall while `stat_rd` is low.
- R5: When `stat_rd` is high at a clock edge, all status bits clear at that edge and `irq` falls with them.
- R6: If a qualified, enabled event comes at the same edge as a read, that event's status bit is set after the edge. All older bits are cleared.
- R7: `irq` is high exactly when at least one status bit is set.
- R8: When `group_mode[0]` is 1 (low pair grouped, 9-bit), events on channel index 1 are dropped on both interfaces. Channel index 0 still reports.
- R9: When `group_mode[1]` is 1 (high pair grouped, 9-bit), events on channel index 3 are dropped on both interfaces. Channel index 2 still reports.
- R10: When `group_mode[3:2]` is 2'b11 (quad grouping, 10-bit), only channel index 0 reports, whatever the value of `group_mode[1:0]`. Any other value of `group_mode[3:2]` leaves pairing to bits [1:0].
- R11: A channel with `is_adc[k]` = 0 (DAC use) produces no done pulse and no status bit.
- R12: Done pulses do not depend on `irq_mask` or `stat_rd`. A masked channel, or an event that comes during a read, still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_end | input | 4 | Raw per-channel end-of-conversion events |
| is_adc | input | 4 | Per-channel ADC (1) or DAC (0) use |
| group_mode | input | 4 | Grouping code: [0] low pair, [1] high pair, [3:2]=11 quad |
| irq_mask | input | 4 | Per-channel interrupt enable |
| stat_rd | input | 1 | Processor read strobe of the status nibble |
| done_pulse | output | 4 | One-cycle done pulses toward the logic |
| status | output | 4 | Sticky status nibble toward the processor |
| irq | output | 1 | Processor interrupt |

## Verification
The event patterns are single channels one at a time, all four channels at once, and all four under a partial mask. Comparing these shows whether the pulse path and the status path are filtered separately. All-channel bursts are repeated under each grouping code and under a mixed ADC/DAC setup, so each folding rule shows up as a distinct missing-bit pattern. Code 4'b1011 is included to show that pairs-only is different from the quad. A read issued together with a new event separates "clear, then set" from "clear everything".

// File: rtl/cdi_pkg.sv
package cdi_pkg;
  localparam int NCH = 4;
  localparam int QUAD_LO = 2;

  typedef struct packed {
    logic quad;
    logic pair_hi;
    logic pair_lo;
  } grp_cfg_t;

  function automatic grp_cfg_t decode_grp(input logic [NCH-1:0] code);
    grp_cfg_t g;
    g.quad    = (code[NCH-1:QUAD_LO] == 2'b11);
    g.pair_lo = code[0];
    g.pair_hi = code[1];
    return g;
  endfunction

  // channels allowed to report under a grouping
  function automatic logic [NCH-1:0] report_allow(input grp_cfg_t g);
    logic [NCH-1:0] a;
    for (int k = 0; k < NCH; k++) begin
      a[k] = 1'b1;
      if (g.quad && k != 0) a[k] = 1'b0;
      if ((k % 2) == 1) begin
        if (k / 2 == 0 && g.pair_lo) a[k] = 1'b0;
        if (k / 2 == 1 && g.pair_hi) a[k] = 1'b0;
      end
    end
    return a;
  endfunction
endpackage

// File: rtl/cdi_event_qual.sv
module cdi_event_qual
  import cdi_pkg::*;
(
  input  logic [NCH-1:0] conv_end,
  input  logic [NCH-1:0] is_adc,
  input  logic [NCH-1:0] group_mode,
  output logic [NCH-1:0] qual_evt
);
  grp_cfg_t       cfg;
  logic [NCH-1:0] allow;

  always_comb begin
    cfg      = decode_grp(group_mode);
    allow    = report_allow(cfg);
    qual_evt = conv_end & is_adc & allow;
  end
endmodule

// File: rtl/cdi_pulse_gen.sv
module cdi_pulse_gen
  import cdi_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] qual_evt,
  output logic [NCH-1:0] done_pulse
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) done_pulse[k] <= 1'b0;
      else        done_pulse[k] <= qual_evt[k];
    end

    // R2: each pulse lasts one cycle unless a fresh event arrives
    p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse[k] && !qual_evt[k]) |=> !done_pulse[k]);
  end
endmodule

// File: rtl/cdi_sticky_status.sv
module cdi_sticky_status
  import cdi_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] qual_evt,
  input  logic [NCH-1:0] irq_mask,
  input  logic           stat_rd,
  output logic [NCH-1:0] status
);
  logic [NCH-1:0] set_vec;
  logic [NCH-1:0] keep_vec;

  assign set_vec  = qual_evt & irq_mask;
  assign keep_vec = stat_rd ? '0 : status;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= keep_vec | set_vec;
  end

  // R5: a read with no new event leaves nothing set
  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && qual_evt == '0) |=> (status == '0));

  // R4: without a read no bit falls
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status & $past(status)) == $past(status)));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    // R3: a bit only rises when its channel was enabled
    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[k]) |-> $past(irq_mask[k]));
    // R6: an enabled event during a read survives
    p_coincide_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && qual_evt[k] && irq_mask[k]) |=> status[k]);
  end
endmodule

// File: rtl/cdi_irq_ctrl.sv
module cdi_irq_ctrl
  import cdi_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] conv_end,
  input  logic [NCH-1:0] is_adc,
  input  logic [NCH-1:0] group_mode,
  input  logic [NCH-1:0] irq_mask,
  input  logic           stat_rd,
  output logic [NCH-1:0] done_pulse,
  output logic [NCH-1:0] status,
  output logic           irq
);
  logic [NCH-1:0] qual_evt;

  cdi_event_qual u_qual (
    .conv_end   (conv_end),
    .is_adc     (is_adc),
    .group_mode (group_mode),
    .qual_evt   (qual_evt)
  );

  cdi_pulse_gen u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .qual_evt   (qual_evt),
    .done_pulse (done_pulse)
  );

  cdi_sticky_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .qual_evt (qual_evt),
    .irq_mask (irq_mask),
    .stat_rd  (stat_rd),
    .status   (status)
  );

  assign irq = |status;

  // R5: interrupt only falls after a read
  p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(stat_rd));

  // R8: grouped low pair never pulses its second channel
  p_fold_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse[1] |-> !$past(group_mode[0] || group_mode[3:2] == 2'b11));

  // R9: grouped high pair never pulses its second channel
  p_fold_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse[3] |-> !$past(group_mode[1] || group_mode[3:2] == 2'b11));

  // R10: quad grouping silences channel index 2
  p_fold_quad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse[2] |-> !$past(group_mode[3:2] == 2'b11));

  for (genvar k = 0; k < NCH; k++) begin : g_src
    // R11: a pulse needs a raw event on an ADC channel
    p_pulse_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse[k] |-> $past(conv_end[k] && is_adc[k]));
  end
endmodule

// File: tb/test_cdi_irq_ctrl.sv
module test_cdi_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] conv_end = '0, is_adc = 4'hF, group_mode = '0, irq_mask = 4'hF;
  logic       stat_rd = 1'b0;
  logic [3:0] done_pulse, status;
  logic       irq;
  logic [3:0] dp, st;
  logic       iq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cdi_irq_ctrl i_cdi_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_end(conv_end), .is_adc(is_adc),
    .group_mode(group_mode), .irq_mask(irq_mask), .stat_rd(stat_rd),
    .done_pulse(done_pulse), .status(status), .irq(irq));

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // apply inputs for one edge, sample outputs after it
  task automatic step(input logic [3:0] ev, input logic rd);
    @(negedge clk);
    conv_end = ev; stat_rd = rd;
    @(negedge clk);
    dp = done_pulse; st = status; iq = irq;
    conv_end = '0; stat_rd = 1'b0;
  endtask

  task automatic clear_all();
    step(4'h0, 1'b1);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk(done_pulse, 4'h0, "R1 pulse in reset");
    chk({3'b0, irq}, 4'h0, "R1 irq in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(status, 4'h0, "R1 status after reset");
  endtask

  task automatic t_indep();
    for (int k = 0; k < 4; k++) begin
      step(4'(1 << k), 1'b0);
      chk(dp, 4'(1 << k), "R2 single-channel pulse");
      step(4'h0, 1'b0);
      chk(dp, 4'h0, "R2 pulse one cycle");
    end
    chk(st, 4'hF, "R4 status accumulates");
    chk({3'b0, iq}, 4'h1, "R7 irq with status set");
    step(4'h0, 1'b0);
    chk(st, 4'hF, "R4 status held without read");
    clear_all();
    chk(st, 4'h0, "R5 read clears status");
    chk({3'b0, iq}, 4'h0, "R5 R7 irq falls on read");
  endtask

  task automatic t_mask();
    irq_mask = 4'b0101;
    step(4'hF, 1'b0);
    chk(dp, 4'hF, "R12 masked channels still pulse");
    chk(st, 4'b0101, "R3 mask filters status");
    step(4'hF, 1'b1);
    chk(dp, 4'hF, "R12 pulse during read");
    chk(st, 4'b0101, "R6 events during read survive");
    irq_mask = 4'h0;
    clear_all();
    step(4'hF, 1'b0);
    chk(st, 4'h0, "R3 all masked no status");
    chk({3'b0, iq}, 4'h0, "R7 irq low when all masked");
    irq_mask = 4'hF;
  endtask

  task automatic t_coincide();
    step(4'b0001, 1'b0);
    step(4'b0100, 1'b1);
    chk(st, 4'b0100, "R6 new bit survives clear");
    clear_all();
  endtask

  task automatic t_group(input logic [3:0] mode, input logic [3:0] exp, input string tag);
    group_mode = mode;
    step(4'hF, 1'b0);
    chk(dp, exp, tag);
    chk(st, exp, tag);
    clear_all();
    group_mode = 4'h0;
  endtask

  task automatic t_dac();
    is_adc = 4'b1001;
    step(4'hF, 1'b0);
    chk(dp, 4'b1001, "R11 DAC channels silent on pulses");
    chk(st, 4'b1001, "R11 DAC channels silent on status");
    clear_all();
    is_adc = 4'hF;
  endtask

  initial begin
    t_reset();
    t_indep();
    t_mask();
    t_coincide();
    t_group(4'b0001, 4'b1101, "R8 low pair grouped");
    t_group(4'b0010, 4'b0111, "R9 high pair grouped");
    t_group(4'b1100, 4'b0001, "R10 quad grouping");
    t_group(4'b1111, 4'b0001, "R10 quad overrides pairs");
    t_group(4'b1011, 4'b0101, "R10 non-quad code uses pairs");
    t_dac();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule